// File: doc/BRIEF.md
# Byte-lane word access sequencer

This block connects a 16-bit processor core to a 16-bit external memory bus whose 20-bit address picks out a single byte. The core issues one byte or word request at a time, for reading or writing, at any address. The sequencer turns each request into one or two bus cycles. It places write data on the correct byte lanes and drives one active-high enable per lane. For reads it gathers the returned bytes, right-justifies them, and hands them back to the core.

Even addresses use the lower lane (bits 7:0) and odd addresses use the upper lane (bits 15:8). Words are little-endian, so the low byte sits at the lower address. A word that starts at an even address moves in a single bus cycle. A word that starts at an odd address is split into two byte cycles on opposite lanes, and the address of the second cycle wraps modulo 2^20. Each bus cycle lasts until the memory side samples its ready input high. When the final cycle of a request completes, the core sees a one-clock completion pulse.

Top module: `lane_access_seq`

## Requirements
- R1: After reset, bus_cyc, done and bus_lane_en are all 0, req_ready is 1 and rdata is 0.
- R2: A byte access at an even address uses one bus cycle with bus_lane_en = 2'b01. A write drives req_wdata[7:0] on bus bits 7:0 and zero on bits 15:8. A read returns bus bits 7:0 in rdata[7:0], with rdata[15:8] = 0.
- R3: A byte access at an odd address uses one bus cycle with bus_lane_en = 2'b10. A write drives req_wdata[7:0] on bus bits 15:8 and zero on bits 7:0. A read returns bus bits 15:8 in rdata[7:0], with rdata[15:8] = 0.
- R4: A word access at an even address uses one bus cycle with bus_lane_en = 2'b11. The byte at the lower address travels on bits 7:0 and maps to req_wdata[7:0] and rdata[7:0].
- R5: A word access at an odd address A uses two bus cycles. The first cycle is at A with bus_lane_en = 2'b10 and carries the low byte on bits 15:8. The second cycle is at A+1 with bus_lane_en = 2'b01 and carries the high byte on bits 7:0. The read result is {byte at A+1, byte at A}.
- R6: A bus cycle keeps bus_cyc, bus_addr, bus_lane_en, bus_we and bus_wdata unchanged until bus_ready is sampled high at a rising edge. bus_ready has no effect while no cycle is active.
- R7: A request is accepted at a rising edge where req_valid and req_ready are both high, and its first bus cycle is active from that edge onward. req_ready is high only when no request is in progress. done is high for exactly one clock, starting at the edge where the final cycle sees bus_ready.
- R8: The second address of a split word is A+1 modulo 2^20, so a word at 20'hFFFFF uses 20'h00000 for its second cycle.
- R9: rdata changes only when a read request completes. Write requests, and the first cycle of a split read, leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core presents a request |
| req_ready | output | 1 | Sequencer is idle and can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = single byte |
| req_addr | input | 20 | Byte address of the access (the low byte for a word) |
| req_wdata | input | 16 | Write data, right-justified for byte writes |
| done | output | 1 | One-clock pulse when the request has completed |
| rdata | output | 16 | Assembled, right-justified read result |
| bus_cyc | output | 1 | A bus cycle is active |
| bus_we | output | 1 | The active cycle is a write |
| bus_addr | output | 20 | Byte address of the active cycle |
| bus_lane_en | output | 2 | Per-lane enables: bit 0 for bits 7:0, bit 1 for bits 15:8 |
| bus_wdata | output | 16 | Lane-steered write data |
| bus_rdata | input | 16 | Read data returned by memory on both lanes |
| bus_ready | input | 1 | Memory ends the active cycle at this edge |

## Verification
The following are checked on every clock:
- the lane choice for each address parity;
- the full two-lane enable on aligned words;
- the A+1 address and the lower-lane second cycle after a split word's first cycle;
- stable bus signals while bus_ready is low;
- done lasting only one clock and always following a ready edge.

Some behaviours only the bench's scenarios can show, because they depend on data values and memory contents:
- that bytes reach the right addresses in little-endian order, checked against a byte-array memory;
- the wrap from 20'hFFFFF to zero;
- the exact completion latency under inserted wait clocks;
- that rdata survives write requests.

// File: rtl/lane_seq_pkg.sv
package lane_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FIRST  = 2'd1,
      ST_SECOND = 2'd2
   } seq_state_t;

   // A word whose low byte sits on an odd address needs two byte cycles.
   function automatic logic needs_split(input logic is_word, input logic addr_lsb);
      return is_word & addr_lsb;
   endfunction

endpackage

// File: rtl/lane_cycle_plan.sv
module lane_cycle_plan #(
   parameter int ADDR_W = 20,
   parameter int LANES  = 2
) (
   input  logic              active,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic              full_word,
   input  logic              second,
   output logic [ADDR_W-1:0] cyc_addr,
   output logic [LANES-1:0]  lane_en
);

   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   // Second half of a split word moves to the next byte, wrapping naturally.
   assign cyc_addr = second ? base_addr + ONE : base_addr;

   always_comb begin
      lane_en = '0;
      if (active) begin
         if (full_word) lane_en = '1;
         else           lane_en = LANES'(1) << cyc_addr[0];
      end
   end

endmodule

// File: rtl/lane_write_steer.sv
module lane_write_steer #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0]   core_wdata,
   input  logic                full_word,
   input  logic                src_hi,
   input  logic [DATA_W/8-1:0] lane_en,
   output logic [DATA_W-1:0]   lane_wdata
);

   localparam int LANES = DATA_W / 8;

   logic [7:0] single_byte;
   assign single_byte = src_hi ? core_wdata[15:8] : core_wdata[7:0];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_wdata[8*g +: 8] = full_word  ? core_wdata[8*g +: 8] :
                                    lane_en[g] ? single_byte : 8'h00;
   end

endmodule

// File: rtl/lane_read_merge.sv
module lane_read_merge #(
   parameter int DATA_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                capture,
   input  logic                full_word,
   input  logic                split_first,
   input  logic                split_second,
   input  logic [DATA_W/8-1:0] lane_en,
   input  logic [DATA_W-1:0]   lane_rdata,
   output logic [DATA_W-1:0]   rdata
);

   localparam int LANES = DATA_W / 8;

   logic [7:0] picked;
   logic [7:0] lo_hold;

   always_comb begin
      picked = 8'h00;
      for (int i = 0; i < LANES; i++) begin
         if (lane_en[i]) picked = picked | lane_rdata[8*i +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata   <= '0;
         lo_hold <= 8'h00;
      end else if (capture) begin
         if (full_word)         rdata   <= lane_rdata;
         else if (split_first)  lo_hold <= picked;
         else if (split_second) rdata   <= {picked, lo_hold};
         else                   rdata   <= DATA_W'(picked);
      end
   end

   // R9: the result register only moves on a completing read cycle
   assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!capture || split_first) |=> $stable(rdata));

endmodule

// File: rtl/lane_access_seq.sv
module lane_access_seq
   import lane_seq_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_write,
   input  logic                req_word,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                done,
   output logic [DATA_W-1:0]   rdata,
   output logic                bus_cyc,
   output logic                bus_we,
   output logic [ADDR_W-1:0]   bus_addr,
   output logic [DATA_W/8-1:0] bus_lane_en,
   output logic [DATA_W-1:0]   bus_wdata,
   input  logic [DATA_W-1:0]   bus_rdata,
   input  logic                bus_ready
);

   localparam int LANES = DATA_W / 8;

   initial begin
      assert_data_width_cfg: assert (DATA_W == 16 && ADDR_W >= 2)
         else $error("lane_access_seq supports a 16-bit data bus only");
   end

   seq_state_t          state;
   logic [ADDR_W-1:0]   lat_addr;
   logic [DATA_W-1:0]   lat_wdata;
   logic                lat_word;
   logic                lat_we;
   logic                split;
   logic                full_word;
   logic                second;
   logic                beat_end;

   assign split     = needs_split(lat_word, lat_addr[0]);
   assign full_word = lat_word & ~lat_addr[0];
   assign second    = (state == ST_SECOND);
   assign bus_cyc   = (state != ST_IDLE);
   assign bus_we    = bus_cyc & lat_we;
   assign req_ready = (state == ST_IDLE);
   assign beat_end  = bus_cyc & bus_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         lat_addr  <= '0;
         lat_wdata <= '0;
         lat_word  <= 1'b0;
         lat_we    <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  lat_addr  <= req_addr;
                  lat_wdata <= req_wdata;
                  lat_word  <= req_word;
                  lat_we    <= req_write;
                  state     <= ST_FIRST;
               end
            end
            ST_FIRST: begin
               if (bus_ready) begin
                  if (split) state <= ST_SECOND;
                  else begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                  end
               end
            end
            ST_SECOND: begin
               if (bus_ready) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   lane_cycle_plan #(.ADDR_W(ADDR_W), .LANES(LANES)) plan_i (
      .active   (bus_cyc),
      .base_addr(lat_addr),
      .full_word(full_word),
      .second   (second),
      .cyc_addr (bus_addr),
      .lane_en  (bus_lane_en)
   );

   lane_write_steer #(.DATA_W(DATA_W)) steer_i (
      .core_wdata(lat_wdata),
      .full_word (full_word),
      .src_hi    (second),
      .lane_en   (bus_lane_en),
      .lane_wdata(bus_wdata)
   );

   lane_read_merge #(.DATA_W(DATA_W)) merge_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .capture     (beat_end & ~lat_we),
      .full_word   (full_word),
      .split_first (split & (state == ST_FIRST)),
      .split_second(second),
      .lane_en     (bus_lane_en),
      .lane_rdata  (bus_rdata),
      .rdata       (rdata)
   );

   // R2: an even-address cycle always enables the lower lane
   assert_even_lower_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && !bus_addr[0]) |-> bus_lane_en[0]);

   // R3: an odd-address cycle enables the upper lane alone
   assert_odd_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && bus_addr[0]) |-> (bus_lane_en == 2'b10));

   // R4: an aligned word enables both lanes
   assert_word_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FIRST && lat_word && !lat_addr[0]) |-> (bus_lane_en == 2'b11));

   // R5, R8: after a split first cycle, the next cycle sits at A+1 (modulo) on the lower lane
   assert_split_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FIRST && split && bus_ready) |=>
         (bus_cyc && bus_addr == $past(bus_addr) + ADDR_W'(1) && bus_lane_en == 2'b01));

   // R6: a cycle without ready keeps every bus output steady
   assert_hold_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && !bus_ready) |=>
         (bus_cyc && $stable(bus_addr) && $stable(bus_lane_en) &&
          $stable(bus_we) && $stable(bus_wdata)));

   // R7: completion lasts one clock
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: completion only follows a ready edge of an active cycle
   assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(bus_cyc && bus_ready));

endmodule

// File: tb/lane_access_seq_tb_top.sv
`timescale 1ns/1ps
module lane_access_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic        req_word = 1'b0;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        done;
   logic [15:0] rdata;
   logic        bus_cyc;
   logic        bus_we;
   logic [19:0] bus_addr;
   logic [1:0]  bus_lane_en;
   logic [15:0] bus_wdata;
   logic [15:0] bus_rdata = '0;
   logic        bus_ready = 1'b0;

   always #2 clk = ~clk;

   lane_access_seq dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
      .done(done), .rdata(rdata),
      .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_lane_en(bus_lane_en), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ready(bus_ready)
   );

   int n_checks = 0;
   int n_fail   = 0;

   task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Byte-array memory (low 8 address bits) and an independent reference copy
   logic [7:0] mem     [256];
   logic [7:0] ref_mem [256];
   int         waits_cfg = 0;
   int         wcnt = 0;
   logic       idle_ready = 1'b0;
   int         cyc_n = 0;
   logic [19:0] log_addr [4];
   logic [1:0]  log_lane [4];
   logic [15:0] log_wd   [4];

   // Memory responder, acting on falling edges
   always @(negedge clk) begin
      if (!rst_n) begin
         bus_ready <= 1'b0;
         wcnt = 0;
      end else if (bus_cyc) begin
         if (wcnt < waits_cfg) begin
            bus_ready <= 1'b0;
            wcnt++;
         end else begin
            wcnt = 0;
            bus_ready <= 1'b1;
            bus_rdata <= {mem[{bus_addr[7:1], 1'b1}], mem[{bus_addr[7:1], 1'b0}]};
            if (bus_we) begin
               if (bus_lane_en[0]) mem[{bus_addr[7:1], 1'b0}] = bus_wdata[7:0];
               if (bus_lane_en[1]) mem[{bus_addr[7:1], 1'b1}] = bus_wdata[15:8];
            end
            if (cyc_n < 4) begin
               log_addr[cyc_n] = bus_addr;
               log_lane[cyc_n] = bus_lane_en;
               log_wd[cyc_n]   = bus_wdata;
            end
            cyc_n++;
         end
      end else begin
         bus_ready <= idle_ready;
         bus_rdata <= 16'h0000;
      end
   end

   typedef struct packed {
      logic        we;
      logic        word;
      logic [19:0] addr;
      logic [15:0] wdata;
      logic [1:0]  waits;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 20'h00020, 16'h00A1, 2'd0},
      '{1'b1, 1'b0, 20'h00021, 16'h00B2, 2'd1},
      '{1'b0, 1'b1, 20'h00020, 16'h0000, 2'd0},
      '{1'b1, 1'b1, 20'h00040, 16'hC3D4, 2'd0},
      '{1'b0, 1'b0, 20'h00041, 16'h0000, 2'd2},
      '{1'b1, 1'b1, 20'h00063, 16'h1E2F, 2'd1},
      '{1'b0, 1'b1, 20'h00063, 16'h0000, 2'd0},
      '{1'b0, 1'b0, 20'h00064, 16'h0000, 2'd0},
      '{1'b0, 1'b1, 20'h00062, 16'h0000, 2'd3},
      '{1'b1, 1'b1, 20'hFFFFF, 16'h7788, 2'd0},
      '{1'b0, 1'b0, 20'h00000, 16'h0000, 2'd0},
      '{1'b0, 1'b1, 20'hFFFFF, 16'h0000, 2'd1}
   };

   logic [15:0] last_read = 16'h0000;

   task automatic run_op(input vec_t v);
      logic [19:0] a1;
      logic [15:0] exp_rd;
      int          ncyc;
      int          lat;
      string       tg;
      a1   = v.addr + 20'd1;
      ncyc = (v.word && v.addr[0]) ? 2 : 1;
      tg   = !v.word ? (v.addr[0] ? "R3" : "R2") : (v.addr[0] ? "R5" : "R4");
      waits_cfg = int'(v.waits);
      cyc_n = 0;
      @(negedge clk);
      check(req_ready == 1'b1, "R7 req_ready idle", 32'(req_ready), 32'd1);
      req_valid = 1'b1; req_write = v.we; req_word = v.word;
      req_addr = v.addr; req_wdata = v.wdata;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!done && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      check(lat == ncyc * (int'(v.waits) + 1) + 1, "R7 done latency", 32'(lat),
            32'(ncyc * (int'(v.waits) + 1) + 1));
      check(cyc_n == ncyc, {tg, " bus cycle count"}, 32'(cyc_n), 32'(ncyc));
      check(log_addr[0] == v.addr, {tg, " first address"}, 32'(log_addr[0]), 32'(v.addr));
      if (ncyc == 1) begin
         logic [1:0] el;
         el = v.word ? 2'b11 : (v.addr[0] ? 2'b10 : 2'b01);
         check(log_lane[0] == el, {tg, " lane enables"}, 32'(log_lane[0]), 32'(el));
         if (v.we && !v.word)
            check(log_wd[0] == (v.addr[0] ? {v.wdata[7:0], 8'h00} : {8'h00, v.wdata[7:0]}),
                  {tg, " byte lane data, idle lane zero"}, 32'(log_wd[0]), 32'(v.wdata[7:0]));
      end else begin
         check(log_lane[0] == 2'b10, "R5 first lane", 32'(log_lane[0]), 32'h2);
         check(log_lane[1] == 2'b01, "R5 second lane", 32'(log_lane[1]), 32'h1);
         check(log_addr[1] == a1, "R8 second address wraps modulo 2^20", 32'(log_addr[1]), 32'(a1));
         if (v.we)
            check(log_wd[0][15:8] == v.wdata[7:0] && log_wd[1][7:0] == v.wdata[15:8],
                  "R5 split write byte order", {log_wd[0], log_wd[1]}, 32'(v.wdata));
      end
      if (v.we) begin
         ref_mem[v.addr[7:0]] = v.wdata[7:0];
         if (v.word) ref_mem[a1[7:0]] = v.wdata[15:8];
         check(mem[v.addr[7:0]] == ref_mem[v.addr[7:0]] && mem[a1[7:0]] == ref_mem[a1[7:0]] &&
               mem[v.addr[7:0] ^ 8'h01] == ref_mem[v.addr[7:0] ^ 8'h01],
               {tg, " memory contents after write"},
               {mem[a1[7:0]], mem[v.addr[7:0]]}, {ref_mem[a1[7:0]], ref_mem[v.addr[7:0]]});
         check(rdata == last_read, "R9 write leaves rdata", 32'(rdata), 32'(last_read));
      end else begin
         exp_rd = v.word ? {ref_mem[a1[7:0]], ref_mem[v.addr[7:0]]} : {8'h00, ref_mem[v.addr[7:0]]};
         check(rdata == exp_rd, {tg, " read result"}, 32'(rdata), 32'(exp_rd));
         last_read = exp_rd;
      end
      @(negedge clk);
      check(done == 1'b0, "R7 done one clock", 32'(done), 32'd0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i]     = 8'(i) ^ 8'h5A;
         ref_mem[i] = 8'(i) ^ 8'h5A;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(bus_cyc == 1'b0 && done == 1'b0 && bus_lane_en == 2'b00,
            "R1 reset outputs idle", {bus_cyc, done, bus_lane_en}, 32'd0);
      check(req_ready == 1'b1, "R1 req_ready after reset", 32'(req_ready), 32'd1);
      check(rdata == 16'h0000, "R1 rdata after reset", 32'(rdata), 32'd0);

      // R6 ready while idle starts nothing
      idle_ready = 1'b1;
      repeat (4) begin
         @(negedge clk);
         check(bus_cyc == 1'b0 && done == 1'b0, "R6 idle ready ignored",
               {bus_cyc, done}, 32'd0);
      end
      idle_ready = 1'b0;
      @(negedge clk);

      for (int k = 0; k < NV; k++) run_op(VECS[k]);

      // Directed: split read held in wait, rdata must not move between cycles (R9)
      begin
         vec_t d;
         d = '{1'b0, 1'b1, 20'h00041, 16'h0000, 2'd3};
         run_op(d);
         d = '{1'b0, 1'b0, 20'h00022, 16'h0000, 2'd0};
         run_op(d);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule